// File: doc/BRIEF.md
# Trace Outcome Predictor

This block is a program-counter-indexed prediction table for a processor that speculates over whole traces. A trace is the run of instructions between two backward branches. When the front end is about to fetch a trace, it presents the trace's start address on the lookup port. If the table is confident, the block answers with a hit. With the hit it supplies the predicted end address of the trace and a small set of predicted live-output registers, each given as a register id and a value. The front end can then skip the trace and let a later checker confirm the guess.

Every tracked quantity in an entry is called a lane. Lane 0 is the trace end address, and lanes 1 to SLOTS are the live-output values. Each lane keeps a short history of its past outcomes, a stride and a 2-bit confidence counter. The block predicts a lane in one of two ways. Context prediction looks back in the history for the newest earlier occurrence of the latest value and predicts the value that came after it. Stride prediction adds the last stride to the latest value and is used when the context search finds nothing. When a trace completes, the update port delivers its real outcome. The block then trains the matching entry or allocates a new one.

The table is 2-way set associative with one LRU bit per set. Traces shorter than the minimum length or longer than the maximum length are never learned.

Top module: `tlvp_top`

## Requirements
- R1: After reset no lookup is valid and every way is invalid, so the first lookup of any address reports predHit = 0.
- R2: A lookup presented in cycle t produces predValid = 1 and its result after the next rising edge. The lookup sees table state from before any update accepted in that same cycle. predValid is 0 in any cycle after one without a lookup.
- R3: The set index is startPc[log2(NUM_ENTRIES/2)-1:0] and the tag is the remaining upper address bits. A way matches only when it is valid and its stored tag equals the tag of the address.
- R4: predHit = 1 only when a way matches and every lane of that way has confidence of 2 or more. When predHit = 0, predFinalPc, predValues and predRegIds read 0.
- R5: An update whose updLen is below MIN_LEN (8) or above MAX_LEN (64) changes nothing. Lengths of exactly 8 and exactly 64 are accepted.
- R6: An accepted update that matches no way allocates a way. The block takes way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's LRU bit. The new entry fills every history position with the new value and starts with stride 0 and confidence 0 in every lane.
- R7: After any accepted update to way w of a set, the set's LRU bit names the other way (1 - w) as the next victim.
- R8: An accepted update to a matching way compares each lane's current prediction with the new value. If they are equal, that lane's confidence counts up and saturates at 3. If they differ, it drops to 0.
- R9: On an update to a matching way, each lane's stride becomes the new value minus the newest stored value. The history shifts by one, with the new value entering at position 0 and the oldest value being dropped.
- R10: A lane's prediction is history[k-1] for the smallest k in 1..HIST-1 with history[k] equal to history[0]. If there is no such k, the prediction is history[0] + stride. predValues carries slot i in bits [i*DATA_W +: DATA_W], and predRegIds carries the ids of the most recent update in the same slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkPc | input | PC_W | Start address of the candidate trace |
| updValid | input | 1 | Completed-trace outcome present |
| updStartPc | input | PC_W | Start address of the completed trace |
| updFinalPc | input | PC_W | Actual end address of the completed trace |
| updLen | input | LEN_W | Instruction count of the completed trace |
| updRegIds | input | SLOTS*RID_W | Live-output register ids, slot i at [i*RID_W +: RID_W] |
| updValues | input | SLOTS*DATA_W | Live-output values, slot i at [i*DATA_W +: DATA_W] |
| predValid | output | 1 | Lookup result is present |
| predHit | output | 1 | Trace may be skipped |
| predFinalPc | output | PC_W | Predicted end address |
| predRegIds | output | SLOTS*RID_W | Predicted live-output register ids |
| predValues | output | SLOTS*DATA_W | Predicted live-output values |

## Verification
A lookup's answer appears exactly one rising edge after the request. An update becomes visible to lookups from the cycle after it is accepted. The bench therefore drives each request on a falling edge and works out the expected answer from its own model of the table as the table stood before that cycle's update. It applies the update to the model only after the rising edge and compares the outputs on the following falling edge. Directed sequences cover stride training up to the confidence threshold, a repeating pattern caught by the context search, rejected and boundary lengths, and way replacement in a shared set.

// File: rtl/tlvp_pkg.sv
package tlvp_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic wrEn;     // accepted update this cycle
    logic alloc;    // update misses, fresh entry into wrWay
    logic wrWay;    // way written by the update
    logic lkEn;     // lookup present this cycle
    logic lkTagHit; // a valid way matches the lookup tag
    logic lkWay;    // the matching way
  } tlvpStrobes_t;
endpackage

// File: rtl/tlvp_lane_pred.sv
module tlvp_lane_pred #(
  parameter int LANE_W = 32,
  parameter int HIST   = 9
) (
  input  logic [HIST*LANE_W-1:0] histFlat,
  input  logic [LANE_W-1:0]      stride,
  output logic [LANE_W-1:0]      pred
);
  logic [LANE_W-1:0] newest;
  logic              found;

  assign newest = histFlat[LANE_W-1:0];

  // Context search: the newest earlier repeat of the latest value wins,
  // otherwise fall back to stride extrapolation.
  always_comb begin
    pred  = newest + stride;
    found = 1'b0;
    for (int k = 1; k < HIST; k++) begin
      if (!found && histFlat[k*LANE_W +: LANE_W] == newest) begin
        pred  = histFlat[(k-1)*LANE_W +: LANE_W];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlvp_ctrl.sv
module tlvp_ctrl
  import tlvp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int NUM_SETS = 32,
  parameter int MIN_LEN  = 8,
  parameter int MAX_LEN  = 64,
  parameter int LEN_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lkValid,
  input  logic [PC_W-1:0]             lkPc,
  input  logic                        updValid,
  input  logic [PC_W-1:0]             updPc,
  input  logic [LEN_W-1:0]            updLen,
  output tlvpStrobes_t                str,
  output logic [$clog2(NUM_SETS)-1:0] lkSet,
  output logic [$clog2(NUM_SETS)-1:0] updSet
);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = PC_W - IDX_W;

  logic [TAG_W-1:0]      tagMem [NUM_SETS][2];
  logic [NUM_SETS*2-1:0] validBits;
  logic [NUM_SETS-1:0]   lruBits;

  logic [TAG_W-1:0] lkTag, updTag;
  logic [1:0]       lkMatch, updMatch;
  logic             lenOk, updHit, updHitWay, victim;

  assign lkSet  = lkPc[IDX_W-1:0];
  assign lkTag  = lkPc[PC_W-1:IDX_W];
  assign updSet = updPc[IDX_W-1:0];
  assign updTag = updPc[PC_W-1:IDX_W];

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      lkMatch[w]  = validBits[{lkSet, 1'(w)}]  && (tagMem[lkSet][w]  == lkTag);
      updMatch[w] = validBits[{updSet, 1'(w)}] && (tagMem[updSet][w] == updTag);
    end
  end

  assign lenOk     = (updLen >= LEN_W'(MIN_LEN)) && (updLen <= LEN_W'(MAX_LEN));
  assign updHit    = |updMatch;
  assign updHitWay = updMatch[1];

  // Victim: an empty way first (way 0 before way 1), else the LRU way
  always_comb begin
    if (!validBits[{updSet, 1'b0}])      victim = 1'b0;
    else if (!validBits[{updSet, 1'b1}]) victim = 1'b1;
    else                                 victim = lruBits[updSet];
  end

  always_comb begin
    str.wrEn     = updValid && lenOk;
    str.alloc    = updValid && lenOk && !updHit;
    str.wrWay    = updHit ? updHitWay : victim;
    str.lkEn     = lkValid;
    str.lkTagHit = |lkMatch;
    str.lkWay    = lkMatch[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      lruBits   <= '0;
    end else if (str.wrEn) begin
      validBits[{updSet, str.wrWay}] <= 1'b1;
      lruBits[updSet]                <= ~str.wrWay;
    end
  end

  always_ff @(posedge clk) begin
    if (str.wrEn && str.alloc) tagMem[updSet][str.wrWay] <= updTag;
  end

  // R3: one tag never sits in both ways of a set
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R5: an out-of-range length leaves the valid and LRU state alone
  p_bad_len_no_change_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !lenOk) |=> ($stable(validBits) && $stable(lruBits)));

  // R6: an allocated way is valid from the next cycle on
  p_alloc_marks_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    str.alloc |=> validBits[{$past(updSet), $past(str.wrWay)}]);

  // R7: the written way is no longer the victim
  p_lru_points_away_r7: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |=> (lruBits[$past(updSet)] == !$past(str.wrWay)));
endmodule

// File: rtl/tlvp_datapath.sv
module tlvp_datapath
  import tlvp_pkg::*;
#(
  parameter int LANE_W   = 32,
  parameter int NUM_SETS = 32,
  parameter int SLOTS    = 4,
  parameter int HIST     = 9,
  parameter int RID_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tlvpStrobes_t                str,
  input  logic [$clog2(NUM_SETS)-1:0] lkSet,
  input  logic [$clog2(NUM_SETS)-1:0] updSet,
  input  logic [(SLOTS+1)*LANE_W-1:0] updLanes,
  input  logic [SLOTS*RID_W-1:0]      updRegIds,
  output logic                        predValid,
  output logic                        predHit,
  output logic [(SLOTS+1)*LANE_W-1:0] predLanes,
  output logic [SLOTS*RID_W-1:0]      predRegIds
);
  localparam int NLANE = SLOTS + 1;

  logic [LANE_W-1:0]      hist   [NUM_SETS][2][NLANE][HIST];
  logic [LANE_W-1:0]      stride [NUM_SETS][2][NLANE];
  logic [1:0]             conf   [NUM_SETS][2][NLANE];
  logic [SLOTS*RID_W-1:0] regIds [NUM_SETS][2];

  logic [HIST*LANE_W-1:0] lkHistFlat  [NLANE];
  logic [HIST*LANE_W-1:0] updHistFlat [NLANE];
  logic [LANE_W-1:0]      lkPred  [NLANE];
  logic [LANE_W-1:0]      updPred [NLANE];
  logic [NLANE*LANE_W-1:0] lkPredFlat;
  logic                   lkConfOk, lkHitNow;

  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      for (int k = 0; k < HIST; k++) begin
        lkHistFlat[l][k*LANE_W +: LANE_W]  = hist[lkSet][str.lkWay][l][k];
        updHistFlat[l][k*LANE_W +: LANE_W] = hist[updSet][str.wrWay][l][k];
      end
    end
  end

  // One predictor per lane on the lookup side and one on the training side
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    tlvp_lane_pred #(.LANE_W(LANE_W), .HIST(HIST)) u_lkPred (
      .histFlat(lkHistFlat[l]),
      .stride  (stride[lkSet][str.lkWay][l]),
      .pred    (lkPred[l])
    );
    tlvp_lane_pred #(.LANE_W(LANE_W), .HIST(HIST)) u_updPred (
      .histFlat(updHistFlat[l]),
      .stride  (stride[updSet][str.wrWay][l]),
      .pred    (updPred[l])
    );
    assign lkPredFlat[l*LANE_W +: LANE_W] = lkPred[l];
  end

  always_comb begin
    lkConfOk = 1'b1;
    for (int l = 0; l < NLANE; l++) lkConfOk &= conf[lkSet][str.lkWay][l][1];
  end

  assign lkHitNow = str.lkEn && str.lkTagHit && lkConfOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid  <= 1'b0;
      predHit    <= 1'b0;
      predLanes  <= '0;
      predRegIds <= '0;
    end else begin
      predValid  <= str.lkEn;
      predHit    <= lkHitNow;
      predLanes  <= lkHitNow ? lkPredFlat : '0;
      predRegIds <= lkHitNow ? regIds[lkSet][str.lkWay] : '0;
    end
  end

  // Training and allocation of the addressed way
  always_ff @(posedge clk) begin
    if (str.wrEn) begin
      regIds[updSet][str.wrWay] <= updRegIds;
      for (int l = 0; l < NLANE; l++) begin
        if (str.alloc) begin
          for (int k = 0; k < HIST; k++)
            hist[updSet][str.wrWay][l][k] <= updLanes[l*LANE_W +: LANE_W];
          stride[updSet][str.wrWay][l] <= '0;
          conf[updSet][str.wrWay][l]   <= 2'd0;
        end else begin
          hist[updSet][str.wrWay][l][0] <= updLanes[l*LANE_W +: LANE_W];
          for (int k = 1; k < HIST; k++)
            hist[updSet][str.wrWay][l][k] <= hist[updSet][str.wrWay][l][k-1];
          stride[updSet][str.wrWay][l] <= updLanes[l*LANE_W +: LANE_W]
                                          - hist[updSet][str.wrWay][l][0];
          if (updPred[l] == updLanes[l*LANE_W +: LANE_W])
            conf[updSet][str.wrWay][l] <= (conf[updSet][str.wrWay][l] == 2'd3)
                                          ? 2'd3 : conf[updSet][str.wrWay][l] + 2'd1;
          else
            conf[updSet][str.wrWay][l] <= 2'd0;
        end
      end
    end
  end

  // R2: a result follows every lookup, and only a lookup
  p_valid_follows_lookup_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.lkEn |=> predValid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !str.lkEn |=> !predValid);

  // R4: a hit always comes from a matching tag
  p_hit_needs_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> $past(str.lkTagHit));

  // R8: a fresh way starts with zero confidence in the end-address lane
  p_alloc_clears_conf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.wrEn && str.alloc) |=> (conf[$past(updSet)][$past(str.wrWay)][0] == 2'd0));
endmodule

// File: rtl/tlvp_top.sv
module tlvp_top
  import tlvp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_ENTRIES = 64,
  parameter int SLOTS       = 4,
  parameter int HIST        = 9,
  parameter int RID_W       = 5,
  parameter int MIN_LEN     = 8,
  parameter int MAX_LEN     = 64,
  parameter int LEN_W       = $clog2(MAX_LEN) + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lkValid,
  input  logic [PC_W-1:0]         lkPc,
  input  logic                    updValid,
  input  logic [PC_W-1:0]         updStartPc,
  input  logic [PC_W-1:0]         updFinalPc,
  input  logic [LEN_W-1:0]        updLen,
  input  logic [SLOTS*RID_W-1:0]  updRegIds,
  input  logic [SLOTS*DATA_W-1:0] updValues,
  output logic                    predValid,
  output logic                    predHit,
  output logic [PC_W-1:0]         predFinalPc,
  output logic [SLOTS*RID_W-1:0]  predRegIds,
  output logic [SLOTS*DATA_W-1:0] predValues
);
  localparam int NUM_SETS = NUM_ENTRIES / 2;
  localparam int IDX_W    = $clog2(NUM_SETS);
  localparam int LANE_W   = (PC_W > DATA_W) ? PC_W : DATA_W;
  localparam int NLANE    = SLOTS + 1;

  tlvpStrobes_t            str;
  logic [IDX_W-1:0]        lkSet, updSet;
  logic [NLANE*LANE_W-1:0] updLanes, predLanes;

  // Lane 0 is the end address, lanes 1..SLOTS the live-output values
  always_comb begin
    updLanes[0 +: LANE_W] = LANE_W'(updFinalPc);
    for (int s = 0; s < SLOTS; s++)
      updLanes[(s+1)*LANE_W +: LANE_W] = LANE_W'(updValues[s*DATA_W +: DATA_W]);
  end

  always_comb begin
    predFinalPc = predLanes[PC_W-1:0];
    for (int s = 0; s < SLOTS; s++)
      predValues[s*DATA_W +: DATA_W] = predLanes[(s+1)*LANE_W +: DATA_W];
  end

  tlvp_ctrl #(
    .PC_W(PC_W), .NUM_SETS(NUM_SETS), .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc),
    .updValid(updValid), .updPc(updStartPc), .updLen(updLen),
    .str(str), .lkSet(lkSet), .updSet(updSet)
  );

  tlvp_datapath #(
    .LANE_W(LANE_W), .NUM_SETS(NUM_SETS), .SLOTS(SLOTS),
    .HIST(HIST), .RID_W(RID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .lkSet(lkSet), .updSet(updSet),
    .updLanes(updLanes), .updRegIds(updRegIds),
    .predValid(predValid), .predHit(predHit),
    .predLanes(predLanes), .predRegIds(predRegIds)
  );
endmodule

// File: tb/sim_tlvp_top.sv
`timescale 1ns/1ps
module sim_tlvp_top;
  localparam int PC_W = 32, DW = 32, NE = 64, SLOTS = 4, HIST = 9, RID_W = 5;
  localparam int LEN_W = 8, NS = NE / 2, IDXW = 5, TAGW = PC_W - IDXW, NL = SLOTS + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkValid = 0, updValid = 0;
  logic [PC_W-1:0] lkPc = '0, updStartPc = '0, updFinalPc = '0;
  logic [LEN_W-1:0] updLen = '0;
  logic [SLOTS*RID_W-1:0] updRegIds = '0;
  logic [SLOTS*DW-1:0] updValues = '0;
  logic predValid, predHit;
  logic [PC_W-1:0] predFinalPc;
  logic [SLOTS*RID_W-1:0] predRegIds;
  logic [SLOTS*DW-1:0] predValues;

  always #2.5 clk = ~clk;

  tlvp_top u0 (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Reference model of the table
  logic [31:0] mHist [NS][2][NL][HIST];
  logic [31:0] mStride [NS][2][NL];
  int          mConf [NS][2][NL];
  logic [SLOTS*RID_W-1:0] mIds [NS][2];
  bit          mValid [NS][2];
  bit          mLru [NS];
  logic [TAGW-1:0] mTag [NS][2];

  // Stimulus pool
  logic [31:0] poolPc [8];
  bit          poolCyc [8];
  int          poolCnt [8];

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mPred(int s, int w, int l);
    for (int k = 1; k < HIST; k++)
      if (mHist[s][w][l][k] == mHist[s][w][l][0]) return mHist[s][w][l][k-1];
    return mHist[s][w][l][0] + mStride[s][w][l];
  endfunction

  function automatic logic [31:0] genLane(int i, int l, int n);
    int cyc[3] = '{3, 7, 1};
    if (poolCyc[i]) return 32'(cyc[(n + l) % 3] + l * 16 + i);
    return 32'(i * 1000 + l * 100 + n * (l + 1) * 3);
  endfunction

  task automatic mUpdate(input logic [31:0] upc, input logic [LEN_W-1:0] ulen,
                         input logic [31:0] lanes [NL], input logic [SLOTS*RID_W-1:0] ids);
    int s; int w; bit hit;
    logic [TAGW-1:0] t;
    if (ulen < 8 || ulen > 64) return;   // R5
    s = int'(upc[IDXW-1:0]); t = upc[PC_W-1:IDXW];
    hit = 0; w = 0;
    for (int x = 0; x < 2; x++) if (mValid[s][x] && mTag[s][x] == t) begin hit = 1; w = x; end
    if (hit) begin
      for (int l = 0; l < NL; l++) begin
        logic [31:0] p;
        p = mPred(s, w, l);
        mConf[s][w][l] = (p == lanes[l]) ? ((mConf[s][w][l] == 3) ? 3 : mConf[s][w][l] + 1) : 0;
        mStride[s][w][l] = lanes[l] - mHist[s][w][l][0];
        for (int k = HIST - 1; k > 0; k--) mHist[s][w][l][k] = mHist[s][w][l][k-1];
        mHist[s][w][l][0] = lanes[l];
      end
    end else begin
      if (!mValid[s][0]) w = 0; else if (!mValid[s][1]) w = 1; else w = int'(mLru[s]);
      mValid[s][w] = 1; mTag[s][w] = t;
      for (int l = 0; l < NL; l++) begin
        for (int k = 0; k < HIST; k++) mHist[s][w][l][k] = lanes[l];
        mStride[s][w][l] = 0; mConf[s][w][l] = 0;
      end
    end
    mIds[s][w] = ids;
    mLru[s] = (w == 0);
  endtask

  // One cycle: drive at a falling edge, expect from pre-update model, check next falling edge
  task automatic step(input bit lv, input int li, input bit uv, input int ui,
                      input logic [LEN_W-1:0] ulen, input bit noise, input string tag);
    logic [31:0] lanes [NL];
    logic [SLOTS*RID_W-1:0] ids;
    bit eHit; int s; int w; logic [TAGW-1:0] t;
    logic [31:0] eFin; logic [SLOTS*DW-1:0] eVals; logic [SLOTS*RID_W-1:0] eIds;
    for (int l = 0; l < NL; l++)
      lanes[l] = noise ? $urandom : genLane(ui, l, poolCnt[ui]);
    ids = SLOTS*RID_W'({$urandom});
    lkValid = lv; lkPc = poolPc[li];
    updValid = uv; updStartPc = poolPc[ui]; updLen = ulen; updRegIds = ids;
    updFinalPc = lanes[0];
    for (int i = 0; i < SLOTS; i++) updValues[i*DW +: DW] = lanes[i+1];
    s = int'(poolPc[li][IDXW-1:0]); t = poolPc[li][PC_W-1:IDXW];
    eHit = 0; eFin = 0; eVals = 0; eIds = 0; w = 0;
    for (int x = 0; x < 2; x++) if (mValid[s][x] && mTag[s][x] == t) begin eHit = 1; w = x; end
    if (eHit) for (int l = 0; l < NL; l++) if (mConf[s][w][l] < 2) eHit = 0;
    if (eHit) begin
      eFin = mPred(s, w, 0); eIds = mIds[s][w];
      for (int i = 0; i < SLOTS; i++) eVals[i*DW +: DW] = mPred(s, w, i + 1);
    end
    @(posedge clk);
    if (uv) begin
      mUpdate(poolPc[ui], ulen, lanes, ids);
      if (!noise) poolCnt[ui]++;
    end
    @(negedge clk);
    lkValid = 0; updValid = 0;
    chk({tag, " R2 predValid"}, 160'(predValid), 160'(lv));
    if (lv) begin
      chk({tag, " R4 predHit"}, 160'(predHit), 160'(eHit));
      chk({tag, " R10 predFinalPc"}, 160'(predFinalPc), 160'(eFin));
      chk({tag, " R10 predValues"}, 160'(predValues), 160'(eVals));
      chk({tag, " R10 predRegIds"}, 160'(predRegIds), 160'(eIds));
    end
  endtask

  task automatic train(input int i, input int n, input logic [LEN_W-1:0] len, input string tag);
    for (int j = 0; j < n; j++) step(0, i, 1, i, len, 0, tag);
  endtask

  initial begin
    #(5.0 * 190000);
    nFails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Pool: 0,3,4,7 share set 3; 1,2 share set 7
    poolPc[0] = {27'd1, 5'd3};  poolCyc[0] = 0;
    poolPc[1] = {27'd1, 5'd7};  poolCyc[1] = 1;
    poolPc[2] = {27'd2, 5'd7};  poolCyc[2] = 0;
    poolPc[3] = {27'd2, 5'd3};  poolCyc[3] = 0;
    poolPc[4] = {27'd3, 5'd3};  poolCyc[4] = 1;
    poolPc[5] = {27'd9, 5'd12}; poolCyc[5] = 0;
    poolPc[6] = {27'd4, 5'd20}; poolCyc[6] = 1;
    poolPc[7] = {27'd4, 5'd3};  poolCyc[7] = 0;
    for (int i = 0; i < 8; i++) poolCnt[i] = 0;
    for (int s = 0; s < NS; s++) begin
      mLru[s] = 0; mValid[s][0] = 0; mValid[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 predValid after reset", 160'(predValid), 160'(0));
    chk("R1 predHit after reset", 160'(predHit), 160'(0));
    step(1, 0, 0, 0, 8'd20, 0, "R1 first lookup misses");

    // R8: stride entry below threshold, then confident
    train(0, 3, 8'd20, "R8 train");
    step(1, 0, 0, 0, 8'd20, 0, "R4 below threshold");
    chk("R4 three updates give no hit", 160'(predHit), 160'(0));
    train(0, 2, 8'd20, "R9 train");
    step(1, 0, 0, 0, 8'd20, 0, "R8 trained");
    chk("R8 trained stride entry hits", 160'(predHit), 160'(1));
    // R2: same-cycle lookup and update of one entry
    step(1, 0, 1, 0, 8'd30, 0, "R2 same cycle");
    step(1, 0, 0, 0, 8'd30, 0, "R2 after update");

    // R10: repeating pattern learned by context search
    train(1, 8, 8'd16, "R10 context train");
    step(1, 1, 0, 1, 8'd16, 0, "R10 context");
    chk("R10 repeating pattern hits", 160'(predHit), 160'(1));

    // R5: rejected lengths do not disturb a trained entry
    step(0, 0, 1, 0, 8'd7, 1, "R5 len 7");
    step(0, 0, 1, 0, 8'd65, 1, "R5 len 65");
    step(1, 0, 0, 0, 8'd20, 0, "R5 after rejects");
    chk("R5 entry still hits after rejected updates", 160'(predHit), 160'(1));
    step(0, 5, 1, 5, 8'd7, 0, "R5 fresh reject");
    step(1, 5, 0, 5, 8'd7, 0, "R5 fresh lookup");
    for (int j = 0; j < 5; j++) step(0, 5, 1, 5, (j % 2) ? 8'd64 : 8'd8, 0, "R5 bounds");
    step(1, 5, 0, 5, 8'd8, 0, "R5 bounds lookup");
    chk("R5 lengths 8 and 64 accepted", 160'(predHit), 160'(1));

    // R6/R7: replacement in set 3 (A in way 0)
    step(0, 0, 1, 3, 8'd20, 0, "R6 alloc D");
    step(1, 0, 0, 0, 8'd20, 0, "R6 A kept");
    chk("R6 empty way taken before eviction", 160'(predHit), 160'(1));
    step(0, 0, 1, 0, 8'd20, 0, "R7 touch A");
    step(0, 0, 1, 4, 8'd20, 0, "R7 alloc E");
    step(1, 0, 0, 0, 8'd20, 0, "R7 A survives");
    chk("R7 recently used way survives eviction", 160'(predHit), 160'(1));
    step(1, 3, 0, 0, 8'd20, 0, "R3 D evicted");
    chk("R3 evicted tag misses", 160'(predHit), 160'(0));

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int li; int ui; int r; logic [LEN_W-1:0] len;
      li = $urandom_range(0, 7); ui = $urandom_range(0, 7);
      r = $urandom_range(0, 9);
      len = (r == 0) ? LEN_W'($urandom_range(0, 7)) :
            (r == 1) ? LEN_W'($urandom_range(65, 127)) : LEN_W'($urandom_range(8, 64));
      step($urandom_range(0, 9) < 7, li, $urandom_range(0, 9) < 6, ui, len,
           $urandom_range(0, 15) == 0, "R10 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule